// File: doc/BRIEF.md
# Register Slave with Access-Type Errors and Power-Down Gate

This block is the bus-facing register file of a peripheral. It sits on an AHB-style pipelined bus, decodes a 4 kB address window and gives the CPU word-wide access to a small set of control, status, command and interrupt registers. For every access it consults a per-register access type (read-write, read-only, write-only, or reserved). If the access is not allowed, or if the word shape is wrong, it answers with a two-cycle error response. While the power-down bit is set, every register except the power-down register itself is fenced off with error responses.

Ordinary writes are posted. The data phase finishes with no wait state, and the write is parked in a one-entry buffer that is applied at the following clock edge. If another transfer follows at once, its data phase is held for one cycle so that the parked write lands first, which keeps all writes and reads in issue order. Writes to the interrupt enable, set and clear registers are not posted. They hold the data phase for one cycle, and the register is changed before the okay response is given.

The controller is a five-state machine. IDLE: no data phase is pending, and a parked write is applied here. DATA: the data phase of an accepted transfer, which completes, starts an error, or starts a non-posted wait. DRAIN: a one-cycle stall while a parked write is applied. ERRTAIL: the second, ready-high cycle of an error. NPACK: the ready-high okay cycle that follows a non-posted write. The transitions are as follows. IDLE, ERRTAIL and NPACK go to DATA on an accepted transfer and to IDLE otherwise. DATA goes to ERRTAIL on an illegal access and to NPACK on a non-posted write. When DATA completes, it goes to DRAIN if it completed a posted write and a new transfer was accepted, to DATA if it completed a read and a new transfer was accepted, and to IDLE if no transfer was accepted. DRAIN always goes to DATA.

Top module: `periph_regslv`

Register map (byte offsets): 0x000 control (read-write), 0x004 configuration (read-write), 0x008 status (read-only, mirrors `status_i`), 0x00C command (write-only), 0x010 interrupt status (read-only), 0x014 interrupt enable (read-write), 0x018 interrupt set (write-only), 0x01C interrupt clear (write-only), 0xFFC power-down (read-write, bit 0). Every other offset is reserved.

## Requirements
- R1: An access is legal only if `hsize` is 3'b010 (word) and `haddr[1:0]` is zero. Any other access gets an error response and changes no register.
- R2: A read of a write-only register (command, interrupt set, interrupt clear) gets an error response.
- R3: A write to a read-only register (status, interrupt status) gets an error response and has no effect. Status always reads back `status_i`.
- R4: A read or write to any offset outside the register map gets an error response and changes no register.
- R5: While power-down bit 0 is 1, every access gets an error response except an access to offset 0xFFC, which completes normally. `pwrdn_o` mirrors the bit.
- R6: An error response takes two cycles. The first has `hreadyout`=0 and `hresp`=1, and the second has `hreadyout`=1 and `hresp`=1.
- R7: A posted write (control, configuration, command, power-down) completes its data phase with no wait state. The register output changes at the second rising edge after the data phase begins. A transfer whose address phase is accepted in the posted write's data phase gets exactly one wait state.
- R8: A write to interrupt enable, set or clear gets exactly one wait state with `hresp`=0. The register is already updated in the ready-high cycle that completes it.
- R9: Writes take effect in issue order. A read returns the value of the most recent earlier write to the same register, even when it directly follows that write.
- R10: Interrupt status bit k (k < 7) is set by a one-cycle pulse on `hw_irq_i[k]`, and hardware can never clear it. Bit 7 has no hardware source. Writing 1s to the set or clear offset sets or clears the matching bits. A hardware set wins over a clear in the same cycle. `irq_o` is the OR of status AND enable.
- R11: After reset, every register is zero, `hreadyout`=1, `hresp`=0 and `irq_o`=0.
- R12: A write to the command offset drives `cmd_o` with the written word and raises `cmd_stb_o` for exactly one cycle when the write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address within the window |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size; only 3'b010 is legal |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hrdata | output | DATA_W | Read data, valid in a completing read data phase |
| hreadyout | output | 1 | Data phase completes when high |
| hresp | output | 1 | 1 = error response |
| status_i | input | DATA_W | Live value shown by the status register |
| hw_irq_i | input | IRQ_W-1 | Hardware interrupt set pulses |
| ctrl_o | output | DATA_W | Control register |
| cfg_o | output | DATA_W | Configuration register |
| cmd_o | output | DATA_W | Last command word |
| cmd_stb_o | output | 1 | One-cycle pulse when a command is applied |
| irq_o | output | 1 | Interrupt request |
| pwrdn_o | output | 1 | Power-down bit |

## Verification
Each response is due at a fixed point. A legal read or posted write is ready in its first data-phase cycle. A non-posted write or an error is ready one cycle later, and an error shows `hresp` in both cycles. A posted register output moves two rising edges after its data phase begins, and the command strobe is high only in the cycle after that second edge. The bench drives on falling edges and samples on the falling edge of each of these cycles. A behavioural model of the register map, the access-type table and the power-down bit predicts the wait count, the response and the read data for every transfer. A pipelined write-then-read pair checks the single drain stall, and the cycles before and after each due edge are sampled to confirm that nothing moves early.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_STAT,
        SEL_CMD,
        SEL_ISTAT,
        SEL_IEN,
        SEL_ISET,
        SEL_ICLR,
        SEL_PWR
    } regsel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_DRAIN,
        ST_ERRTAIL,
        ST_NPACK
    } state_e;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_CFG   = 1;
    localparam int IDX_STAT  = 2;
    localparam int IDX_CMD   = 3;
    localparam int IDX_ISTAT = 4;
    localparam int IDX_IEN   = 5;
    localparam int IDX_ISET  = 6;
    localparam int IDX_ICLR  = 7;

endpackage

// File: rtl/regslv_decode.sv
module regslv_decode
    import regslv_pkg::*;
#(
    parameter int          IDX_W     = 10,
    parameter int          LSB_W     = 2,
    parameter logic [2:0]  SIZE_CODE = 3'b010
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [LSB_W-1:0] lo,
    input  logic [2:0]       size,
    input  logic             write,
    input  logic             pwrdn,
    output regsel_e          sel,
    output logic             err,
    output logic             nonposted
);

    logic can_rd;
    logic can_wr;
    logic shape_bad;

    always_comb begin
        sel = SEL_NONE;
        if (idx == {IDX_W{1'b1}}) begin
            sel = SEL_PWR;
        end else begin
            case (idx)
                IDX_W'(IDX_CTRL):  sel = SEL_CTRL;
                IDX_W'(IDX_CFG):   sel = SEL_CFG;
                IDX_W'(IDX_STAT):  sel = SEL_STAT;
                IDX_W'(IDX_CMD):   sel = SEL_CMD;
                IDX_W'(IDX_ISTAT): sel = SEL_ISTAT;
                IDX_W'(IDX_IEN):   sel = SEL_IEN;
                IDX_W'(IDX_ISET):  sel = SEL_ISET;
                IDX_W'(IDX_ICLR):  sel = SEL_ICLR;
                default:           sel = SEL_NONE;
            endcase
        end
    end

    // access-type table
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        unique case (sel)
            SEL_CTRL, SEL_CFG, SEL_IEN, SEL_PWR: begin
                can_rd = 1'b1;
                can_wr = 1'b1;
            end
            SEL_STAT, SEL_ISTAT: can_rd = 1'b1;
            SEL_CMD, SEL_ISET, SEL_ICLR: can_wr = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        shape_bad = (size != SIZE_CODE) || (lo != '0);
        err = shape_bad
           || (sel == SEL_NONE)
           || (write ? !can_wr : !can_rd)
           || (pwrdn && (sel != SEL_PWR));
        nonposted = write && !err
                 && ((sel == SEL_IEN) || (sel == SEL_ISET) || (sel == SEL_ICLR));
    end

endmodule

// File: rtl/regslv_wbuf.sv
module regslv_wbuf
    import regslv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  regsel_e           fill_sel,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              drain,
    output logic              valid,
    output regsel_e           sel,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            sel   <= SEL_NONE;
            data  <= '0;
        end else if (fill) begin
            valid <= 1'b1;
            sel   <= fill_sel;
            data  <= fill_data;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end

    // a new posted write never lands on an occupied slot
    p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> !valid);

    // a parked write is applied at the very next edge
    p_drain_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/regslv_regfile.sv
module regslv_regfile
    import regslv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  regsel_e           wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  regsel_e           rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] status_i,
    input  logic [IRQ_W-2:0]  hw_irq_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic [DATA_W-1:0] cmd_o,
    output logic              cmd_stb_o,
    output logic              irq_o,
    output logic              pwrdn_o
);

    localparam int PAD_W = DATA_W - IRQ_W;

    logic [IRQ_W-1:0] istat_q;
    logic [IRQ_W-1:0] ien_q;
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] clr_v;
    logic [IRQ_W-1:0] hw_v;

    always_comb begin
        set_v = (wr_en && wr_sel == SEL_ISET) ? wr_data[IRQ_W-1:0] : '0;
        clr_v = (wr_en && wr_sel == SEL_ICLR) ? wr_data[IRQ_W-1:0] : '0;
        hw_v  = {1'b0, hw_irq_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            cfg_o     <= '0;
            cmd_o     <= '0;
            cmd_stb_o <= 1'b0;
            ien_q     <= '0;
            istat_q   <= '0;
            pwrdn_o   <= 1'b0;
        end else begin
            cmd_stb_o <= wr_en && (wr_sel == SEL_CMD);
            istat_q   <= ((istat_q | set_v) & ~clr_v) | hw_v;
            if (wr_en) begin
                case (wr_sel)
                    SEL_CTRL: ctrl_o  <= wr_data;
                    SEL_CFG:  cfg_o   <= wr_data;
                    SEL_CMD:  cmd_o   <= wr_data;
                    SEL_IEN:  ien_q   <= wr_data[IRQ_W-1:0];
                    SEL_PWR:  pwrdn_o <= wr_data[0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL:  rd_data = ctrl_o;
            SEL_CFG:   rd_data = cfg_o;
            SEL_STAT:  rd_data = status_i;
            SEL_ISTAT: rd_data = {{PAD_W{1'b0}}, istat_q};
            SEL_IEN:   rd_data = {{PAD_W{1'b0}}, ien_q};
            SEL_PWR:   rd_data = {{(DATA_W-1){1'b0}}, pwrdn_o};
            default:   rd_data = '0;
        endcase
    end

    assign irq_o = |(istat_q & ien_q);

    p_hw_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_v) |=> ((istat_q & $past(hw_v)) == $past(hw_v)));

    p_soft_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_q[IRQ_W-1]) |-> $past(wr_en && (wr_sel == SEL_ISET)));

    p_cmd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o);

endmodule

// File: rtl/periph_regslv.sv
module periph_regslv
    import regslv_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 8
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    input  logic [DATA_W-1:0] status_i,
    input  logic [IRQ_W-2:0]  hw_irq_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic [DATA_W-1:0] cmd_o,
    output logic              cmd_stb_o,
    output logic              irq_o,
    output logic              pwrdn_o
);

    localparam int         LSB_W     = $clog2(DATA_W / 8);
    localparam int         IDX_W     = ADDR_W - LSB_W;
    localparam logic [2:0] SIZE_CODE = 3'(LSB_W);

    state_e            state_q, state_d;
    logic [IDX_W-1:0]  a_idx;
    logic [LSB_W-1:0]  a_lo;
    logic [2:0]        a_size;
    logic              a_write;

    regsel_e           dec_sel;
    logic              dec_err;
    logic              dec_np;

    logic              buf_valid;
    regsel_e           buf_sel;
    logic [DATA_W-1:0] buf_data;

    logic              accept;
    logic              fill;
    logic              drain;
    logic              np_apply;
    logic              rf_wen;
    regsel_e           rf_wsel;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_rdata;
    logic              unused_htrans0;

    assign unused_htrans0 = htrans[0];
    assign accept = hsel && htrans[1] && hreadyout;

    // address-phase capture
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            a_idx   <= '0;
            a_lo    <= '0;
            a_size  <= '0;
            a_write <= 1'b0;
        end else if (accept) begin
            a_idx   <= haddr[ADDR_W-1:LSB_W];
            a_lo    <= haddr[LSB_W-1:0];
            a_size  <= hsize;
            a_write <= hwrite;
        end
    end

    regslv_decode #(
        .IDX_W     (IDX_W),
        .LSB_W     (LSB_W),
        .SIZE_CODE (SIZE_CODE)
    ) u_decode (
        .idx       (a_idx),
        .lo        (a_lo),
        .size      (a_size),
        .write     (a_write),
        .pwrdn     (pwrdn_o),
        .sel       (dec_sel),
        .err       (dec_err),
        .nonposted (dec_np)
    );

    // write routing
    always_comb begin
        fill     = (state_q == ST_DATA) && !dec_err && !dec_np && a_write;
        drain    = buf_valid && ((state_q == ST_IDLE) || (state_q == ST_DRAIN));
        np_apply = (state_q == ST_DATA) && dec_np;
        rf_wen   = drain || np_apply;
        rf_wsel  = np_apply ? dec_sel : buf_sel;
        rf_wdata = np_apply ? hwdata  : buf_data;
    end

    regslv_wbuf #(
        .DATA_W (DATA_W)
    ) u_wbuf (
        .clk       (hclk),
        .rst_n     (hresetn),
        .fill      (fill),
        .fill_sel  (dec_sel),
        .fill_data (hwdata),
        .drain     (drain),
        .valid     (buf_valid),
        .sel       (buf_sel),
        .data      (buf_data)
    );

    regslv_regfile #(
        .DATA_W (DATA_W),
        .IRQ_W  (IRQ_W)
    ) u_regfile (
        .clk       (hclk),
        .rst_n     (hresetn),
        .wr_en     (rf_wen),
        .wr_sel    (rf_wsel),
        .wr_data   (rf_wdata),
        .rd_sel    (dec_sel),
        .rd_data   (rf_rdata),
        .status_i  (status_i),
        .hw_irq_i  (hw_irq_i),
        .ctrl_o    (ctrl_o),
        .cfg_o     (cfg_o),
        .cmd_o     (cmd_o),
        .cmd_stb_o (cmd_stb_o),
        .irq_o     (irq_o),
        .pwrdn_o   (pwrdn_o)
    );

    // state register
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ERRTAIL, ST_NPACK:
                state_d = accept ? ST_DATA : ST_IDLE;
            ST_DATA: begin
                if (dec_err)      state_d = ST_ERRTAIL;
                else if (dec_np)  state_d = ST_NPACK;
                else if (accept)  state_d = a_write ? ST_DRAIN : ST_DATA;
                else              state_d = ST_IDLE;
            end
            ST_DRAIN:
                state_d = ST_DATA;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
        hrdata    = '0;
        unique case (state_q)
            ST_IDLE, ST_NPACK: ;
            ST_DATA: begin
                if (dec_err) begin
                    hreadyout = 1'b0;
                    hresp     = 1'b1;
                end else if (dec_np) begin
                    hreadyout = 1'b0;
                end else if (!a_write) begin
                    hrdata = rf_rdata;
                end
            end
            ST_DRAIN:   hreadyout = 1'b0;
            ST_ERRTAIL: hresp     = 1'b1;
            default: ;
        endcase
    end

    p_err_tail_r6: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    p_wo_read_r2: assert property (@(posedge hclk) disable iff (!hresetn)
        (state_q == ST_DATA && !a_write && dec_sel == SEL_CMD) |-> hresp);

    p_ro_write_r3: assert property (@(posedge hclk) disable iff (!hresetn)
        (state_q == ST_DATA && a_write && (dec_sel == SEL_STAT || dec_sel == SEL_ISTAT))
            |-> (hresp && !rf_wen));

    p_pd_gate_r5: assert property (@(posedge hclk) disable iff (!hresetn)
        (state_q == ST_DATA && pwrdn_o && dec_sel != SEL_PWR) |-> hresp);

    p_np_applied_r8: assert property (@(posedge hclk) disable iff (!hresetn)
        (state_q == ST_NPACK) |-> $past(rf_wen));

    p_order_r9: assert property (@(posedge hclk) disable iff (!hresetn)
        (state_q == ST_DATA) |-> !buf_valid);

endmodule

// File: tb/periph_regslv_tb.sv
`timescale 1ns/1ps
module periph_regslv_tb;

    logic        clk = 1'b0;
    logic        hresetn;
    logic        hsel;
    logic [11:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [31:0] hwdata;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] status_i;
    logic [6:0]  hw_irq_i;
    logic [31:0] ctrl_o, cfg_o, cmd_o;
    logic        cmd_stb_o, irq_o, pwrdn_o;

    int checks   = 0;
    int failures = 0;

    // behavioural model of the register map
    logic [31:0] m_ctrl = '0, m_cfg = '0;
    logic [7:0]  m_istat = '0, m_ien = '0;
    logic        m_pd = 1'b0;

    always #10 clk = ~clk;

    periph_regslv u_dut (
        .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp), .status_i(status_i), .hw_irq_i(hw_irq_i),
        .ctrl_o(ctrl_o), .cfg_o(cfg_o), .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o),
        .irq_o(irq_o), .pwrdn_o(pwrdn_o)
    );

    task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 reserved, 1 read-write, 2 read-only, 3 write-only
    function automatic int kind(input logic [9:0] idx);
        case (idx)
            10'd0, 10'd1, 10'd5, 10'h3FF: return 1;
            10'd2, 10'd4:                 return 2;
            10'd3, 10'd6, 10'd7:          return 3;
            default:                      return 0;
        endcase
    endfunction

    function automatic bit m_err(input logic w, input logic [11:0] a, input logic [2:0] sz);
        int k;
        k = kind(a[11:2]);
        if (sz != 3'b010 || a[1:0] != 2'b00) return 1'b1;
        if (k == 0) return 1'b1;
        if (m_pd && a[11:2] != 10'h3FF) return 1'b1;
        if (w && k == 2) return 1'b1;
        if (!w && k == 3) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_read(input logic [9:0] idx);
        case (idx)
            10'd0:   return m_ctrl;
            10'd1:   return m_cfg;
            10'd2:   return status_i;
            10'd4:   return {24'd0, m_istat};
            10'd5:   return {24'd0, m_ien};
            10'h3FF: return {31'd0, m_pd};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_write(input logic [9:0] idx, input logic [31:0] d);
        case (idx)
            10'd0:   m_ctrl = d;
            10'd1:   m_cfg = d;
            10'd5:   m_ien = d[7:0];
            10'd6:   m_istat = m_istat | d[7:0];
            10'd7:   m_istat = m_istat & ~d[7:0];
            10'h3FF: m_pd = d[0];
            default: ;
        endcase
    endtask

    // one isolated transfer; hwp is only meaningful on a non-posted write
    task automatic xfer(input logic w, input logic [11:0] a, input logic [2:0] sz,
                        input logic [31:0] d, input logic [6:0] hwp, input string tag);
        int waits;
        bit low_err, low_ok, e, np, ok;
        logic fresp;
        logic [31:0] rd, exp_rd;
        e  = m_err(w, a, sz);
        np = w && !e && (a[11:2] inside {10'd5, 10'd6, 10'd7});
        exp_rd = m_read(a[11:2]);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = w; hsize = sz;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = d; hw_irq_i = hwp;
        waits = 0; low_err = 0; low_ok = 0;
        while (hreadyout !== 1'b1 && waits < 8) begin
            if (hresp) low_err = 1; else low_ok = 1;
            @(negedge clk);
            hw_irq_i = '0;
            waits++;
        end
        hw_irq_i = '0;
        fresp = hresp;
        rd = hrdata;
        if (e)       ok = (waits == 1) && low_err && !low_ok && fresp;
        else if (np) ok = (waits == 1) && low_ok && !low_err && !fresp;
        else         ok = (waits == 0) && !fresp;
        chk(tag, ok, {waits[15:0], 15'd0, fresp}, {15'd0, (e || np), 15'd0, e});
        if (!e && w) begin
            m_write(a[11:2], d);
            if (np) m_istat = m_istat | {1'b0, hwp};
        end
        if (!e && !w) chk(tag, rd === exp_rd, rd, exp_rd);
        if (np) chk(tag, irq_o === |(m_istat & m_ien), {31'd0, irq_o}, {31'd0, |(m_istat & m_ien)});
    endtask

    task automatic hw_pulse(input logic [6:0] v);
        @(negedge clk); hw_irq_i = v;
        @(negedge clk); hw_irq_i = '0;
        m_istat = m_istat | {1'b0, v};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        hresetn = 1'b0; hsel = 0; haddr = '0; htrans = '0; hwrite = 0; hsize = 3'b010;
        hwdata = '0; hw_irq_i = '0; status_i = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk); hresetn = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready/resp", hreadyout === 1'b1 && hresp === 1'b0, {30'd0, hreadyout, hresp}, 32'd2);
        chk("R11 regs", ctrl_o === 0 && cfg_o === 0 && cmd_o === 0 && !cmd_stb_o && !irq_o && !pwrdn_o,
            ctrl_o | cfg_o | cmd_o, 32'd0);

        // R7 posted write: data phase zero-wait, output moves at the second edge
        xfer(1, 12'h000, 3'b010, 32'hA5A5_0001, '0, "R7 posted ctrl");
        @(negedge clk);
        chk("R7 ctrl not yet applied", ctrl_o === 32'd0, ctrl_o, 32'd0);
        @(negedge clk);
        chk("R7 ctrl applied", ctrl_o === 32'hA5A5_0001, ctrl_o, 32'hA5A5_0001);
        xfer(0, 12'h000, 3'b010, '0, '0, "R9 read ctrl");

        // R7/R9 back-to-back posted write then read: one stall, read sees new data
        begin
            logic s0, s1, s2, r1;
            logic [31:0] rd;
            @(negedge clk);
            hsel = 1; htrans = 2'b10; haddr = 12'h004; hwrite = 1; hsize = 3'b010;
            @(negedge clk);
            s0 = hreadyout;
            hwdata = 32'h0BAD_F00D; haddr = 12'h004; hwrite = 0;
            @(negedge clk);
            hsel = 0; htrans = 2'b00;
            s1 = hreadyout; r1 = hresp;
            @(negedge clk);
            s2 = hreadyout; rd = hrdata;
            m_cfg = 32'h0BAD_F00D;
            chk("R7 b2b stall pattern", s0 && !s1 && !r1 && s2, {29'd0, s0, s1, s2}, 32'd5);
            chk("R9 read after write", rd === 32'h0BAD_F00D, rd, 32'h0BAD_F00D);
        end

        xfer(1, 12'h000, 3'b010, 32'd1, '0, "R9 first write");
        xfer(1, 12'h000, 3'b010, 32'd2, '0, "R9 second write");
        xfer(0, 12'h000, 3'b010, '0, '0, "R9 last write wins");

        xfer(0, 12'h00C, 3'b010, '0, '0, "R2 read write-only cmd");
        xfer(0, 12'h018, 3'b010, '0, '0, "R2 read write-only set");
        xfer(1, 12'h008, 3'b010, 32'hFFFF_FFFF, '0, "R3 write read-only status");
        xfer(0, 12'h008, 3'b010, '0, '0, "R3 status unchanged");
        xfer(0, 12'h020, 3'b010, '0, '0, "R4 reserved read");
        xfer(1, 12'h800, 3'b010, 32'hFF, '0, "R4 reserved write");
        xfer(0, 12'h100, 3'b010, '0, '0, "R6 reserved error shape");
        xfer(1, 12'h000, 3'b000, 32'hDEAD, '0, "R1 byte write");
        xfer(0, 12'h002, 3'b010, '0, '0, "R1 misaligned read");
        xfer(0, 12'h000, 3'b010, '0, '0, "R1 ctrl untouched");

        // R12 command strobe
        xfer(1, 12'h00C, 3'b010, 32'h55, '0, "R12 cmd write");
        @(negedge clk);
        chk("R12 strobe not early", cmd_stb_o === 1'b0, {31'd0, cmd_stb_o}, 32'd0);
        @(negedge clk);
        chk("R12 strobe and value", cmd_stb_o === 1'b1 && cmd_o === 32'h55, cmd_o, 32'h55);
        @(negedge clk);
        chk("R12 strobe one cycle", cmd_stb_o === 1'b0, {31'd0, cmd_stb_o}, 32'd0);

        // R8 / R10 interrupt registers
        xfer(1, 12'h014, 3'b010, 32'h81, '0, "R8 enable write");
        xfer(1, 12'h018, 3'b010, 32'h80, '0, "R8 soft set");
        xfer(0, 12'h010, 3'b010, '0, '0, "R10 status after set");
        xfer(1, 12'h01C, 3'b010, 32'h80, '0, "R10 soft clear");
        hw_pulse(7'h01);
        chk("R10 hw set raises irq", irq_o === 1'b1, {31'd0, irq_o}, 32'd1);
        xfer(0, 12'h010, 3'b010, '0, '0, "R10 status after hw set");
        xfer(1, 12'h01C, 3'b010, 32'h01, 7'h01, "R10 hw set beats clear");
        xfer(0, 12'h010, 3'b010, '0, '0, "R10 bit kept");
        xfer(1, 12'h01C, 3'b010, 32'h01, '0, "R10 clear");

        // R5 power-down gate
        xfer(1, 12'hFFC, 3'b010, 32'h1, '0, "R5 set power-down");
        @(negedge clk); @(negedge clk);
        chk("R5 pwrdn_o", pwrdn_o === 1'b1, {31'd0, pwrdn_o}, 32'd1);
        xfer(0, 12'h000, 3'b010, '0, '0, "R5 ctrl read gated");
        xfer(1, 12'h018, 3'b010, 32'h80, '0, "R5 set write gated");
        chk("R5 gated write no effect", irq_o === 1'b0, {31'd0, irq_o}, 32'd0);
        xfer(0, 12'hFFC, 3'b010, '0, '0, "R5 power reg readable");
        xfer(1, 12'hFFC, 3'b010, 32'h0, '0, "R5 clear power-down");
        xfer(0, 12'h000, 3'b010, '0, '0, "R5 ctrl readable again");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule